// File: doc/BRIEF.md
# Fastlock Charge-Pump Current Selector

This block decides which of two 3-bit charge-pump current codes goes to the charge pump. The primary code is for steady operation. The secondary, larger code speeds up settling after the loop is retuned. The choice follows a single gain bit, which software writes through a strobe. Two configuration bits decide what happens after a 1 is written:

- **Direct selection.** The gain bit picks a code and stays where it was written.
- **Manual fastlock.** The boost lasts until software writes a 0.
- **Timed fastlock.** A counter of phase-detector cycles clears the gain bit by itself after a programmable number of cycles, and the primary code returns.

The timeout is 3 + 4·TC phase-detector cycles, where TC is a 4-bit code. It therefore ranges from 3 cycles (code 0) to 63 cycles (code 15).

Phase-detector cycles arrive as one-clock pulses on `pfd_tick`. Power-down holds the timer at its load state, and the gain bit keeps its value. Every pin is a plain level or a one-cycle strobe, so there is no stream interface and no back-pressure.

Top module: `fastlock_ctrl`

## Requirements
- R1: After reset the gain bit is 0, the timer is at zero, and `icp_code` equals `cur_primary`.
- R2: `icp_code` equals `cur_secondary` whenever `gain_bit` is 1 and equals `cur_primary` whenever it is 0, with no clock delay from either code input.
- R3: A cycle with `gain_wr`=1 loads `gain_val` into `gain_bit` at that clock edge, in every mode.
- R4: When `fl_enable`=0 (direct selection), or `fl_enable`=1 with `fl_mode`=0 (manual fastlock), `gain_bit` never clears itself, however many ticks arrive.
- R5: When `fl_enable`=1 and `fl_mode`=1 (timed fastlock), after a 1 is written `gain_bit` clears at the clock edge that samples the (3+4·`tc_code`)-th `pfd_tick` counted after the write. `icp_code` returns to `cur_primary` at that same edge.
- R6: Writing 1 while a timeout runs restarts the count from zero. A write in the same cycle as the expiring tick takes priority, and a write of 0 cancels the timeout.
- R7: While `pwr_down`=1 the timer is held at zero, ticks are ignored and `gain_bit` keeps its value. After release, a full new timeout is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Power-down level; holds the timer at its load state |
| fl_enable | input | 1 | 1 enables fastlock |
| fl_mode | input | 1 | 0 selects manual fastlock, 1 selects timed fastlock |
| tc_code | input | 4 | Timeout code TC; timeout = 3 + 4·TC ticks |
| cur_primary | input | 3 | Primary (steady) current code |
| cur_secondary | input | 3 | Secondary (boost) current code |
| gain_wr | input | 1 | One-cycle strobe that writes the gain bit |
| gain_val | input | 1 | Value written by `gain_wr` |
| pfd_tick | input | 1 | One-cycle pulse per phase-detector cycle |
| icp_code | output | 3 | Selected charge-pump current code |
| gain_bit | output | 1 | Current state of the gain bit |

## Verification
The bench builds the block with its default parameters: 3-bit current codes and a 4-bit timeout code. At this size every timeout code can be run to expiry, and the tick on which the gain bit must fall is computed as 3 + 4·TC. It also covers every pair of primary and secondary codes, in both gain states. Directed sequences cover the restart on a second write, the same-cycle collision between a write and the expiring tick, cancellation by a written 0, and ticks sent during power-down.

// File: rtl/fl_pkg.sv
package fl_pkg;
  // Timeout in phase-detector cycles for a given timer code.
  function automatic int timeout_len(input int tc);
    return 3 + 4 * tc;
  endfunction
endpackage

// File: rtl/fl_gain_reg.sv
module fl_gain_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_val,
  input  logic expire,
  output logic gain_q
);
  // A write always wins; otherwise an expiry clears the bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gain_q <= 1'b0;
    else if (wr)
      gain_q <= wr_val;
    else if (expire)
      gain_q <= 1'b0;
  end
endmodule

// File: rtl/fl_timer.sv
module fl_timer #(
  parameter int TC_W  = 4,
  parameter int TMR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [TC_W-1:0]  tc,
  output logic [TMR_W-1:0] cnt_q,
  output logic             expire
);
  logic [TMR_W-1:0] last_cnt;

  // The last count value before expiry is one less than the timeout.
  always_comb
    last_cnt = TMR_W'(fl_pkg::timeout_len(int'(tc)) - 1);

  assign expire = run && !restart && tick && (cnt_q == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || restart || expire)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fl_cur_sel.sv
module fl_cur_sel #(
  parameter int CODE_W = 3
) (
  input  logic              sel,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  output logic [CODE_W-1:0] code_out
);
  // One multiplexer per bit of the current code.
  for (genvar i = 0; i < CODE_W; i++) begin : g_bit
    assign code_out[i] = sel ? code_b[i] : code_a[i];
  end
endmodule

// File: rtl/fastlock_ctrl.sv
module fastlock_ctrl #(
  parameter int CODE_W = 3,
  parameter int TC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              fl_enable,
  input  logic              fl_mode,
  input  logic [TC_W-1:0]   tc_code,
  input  logic [CODE_W-1:0] cur_primary,
  input  logic [CODE_W-1:0] cur_secondary,
  input  logic              gain_wr,
  input  logic              gain_val,
  input  logic              pfd_tick,
  output logic [CODE_W-1:0] icp_code,
  output logic              gain_bit
);
  localparam int MAX_LEN = fl_pkg::timeout_len((1 << TC_W) - 1);
  localparam int TMR_W   = $clog2(MAX_LEN);

  logic             timed_mode;
  logic             tmr_run;
  logic             tmr_expire;
  logic [TMR_W-1:0] tmr_cnt;

  assign timed_mode = fl_enable & fl_mode;
  assign tmr_run    = timed_mode & gain_bit & ~pwr_down;

  fl_gain_reg u_gain (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (gain_wr),
    .wr_val (gain_val),
    .expire (tmr_expire),
    .gain_q (gain_bit)
  );

  fl_timer #(.TC_W(TC_W), .TMR_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (tmr_run),
    .restart (gain_wr),
    .tick    (pfd_tick),
    .tc      (tc_code),
    .cnt_q   (tmr_cnt),
    .expire  (tmr_expire)
  );

  fl_cur_sel #(.CODE_W(CODE_W)) u_sel (
    .sel      (gain_bit),
    .code_a   (cur_primary),
    .code_b   (cur_secondary),
    .code_out (icp_code)
  );
endmodule

// File: rtl/fl_checker.sv
module fl_checker #(
  parameter int CODE_W = 3,
  parameter int TMR_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_down,
  input logic              fl_enable,
  input logic              fl_mode,
  input logic              gain_wr,
  input logic              gain_val,
  input logic              pfd_tick,
  input logic [CODE_W-1:0] cur_primary,
  input logic [CODE_W-1:0] cur_secondary,
  input logic [CODE_W-1:0] icp_code,
  input logic              gain_bit,
  input logic [TMR_W-1:0]  tmr_cnt
);
  assert_code_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    icp_code == (gain_bit ? cur_secondary : cur_primary));

  assert_write_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gain_wr |=> gain_bit == $past(gain_val));

  assert_no_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fl_enable && fl_mode) && !gain_wr && gain_bit) |=> gain_bit);

  assert_clear_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gain_bit) && !$past(gain_wr)) |-> ($past(pfd_tick) && $past(fl_enable) && $past(fl_mode)));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gain_wr |=> tmr_cnt == '0);

  assert_pd_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> tmr_cnt == '0);

  assert_pd_gain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && !gain_wr) |=> $stable(gain_bit));
endmodule

bind fastlock_ctrl fl_checker #(.CODE_W(CODE_W), .TMR_W(TMR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pwr_down      (pwr_down),
  .fl_enable     (fl_enable),
  .fl_mode       (fl_mode),
  .gain_wr       (gain_wr),
  .gain_val      (gain_val),
  .pfd_tick      (pfd_tick),
  .cur_primary   (cur_primary),
  .cur_secondary (cur_secondary),
  .icp_code      (icp_code),
  .gain_bit      (gain_bit),
  .tmr_cnt       (tmr_cnt)
);

// File: tb/fastlock_ctrl_test.sv
`timescale 1ns/1ps
module fastlock_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_down = 1'b0;
  logic       fl_enable = 1'b0;
  logic       fl_mode = 1'b0;
  logic [3:0] tc_code = 4'd0;
  logic [2:0] cur_primary = 3'd2;
  logic [2:0] cur_secondary = 3'd6;
  logic       gain_wr = 1'b0;
  logic       gain_val = 1'b0;
  logic       pfd_tick = 1'b0;
  logic [2:0] icp_code;
  logic       gain_bit;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fastlock_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .fl_enable(fl_enable),
    .fl_mode(fl_mode), .tc_code(tc_code), .cur_primary(cur_primary),
    .cur_secondary(cur_secondary), .gain_wr(gain_wr), .gain_val(gain_val),
    .pfd_tick(pfd_tick), .icp_code(icp_code), .gain_bit(gain_bit)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Checks the gain bit and the selected code against the expected gain state.
  task automatic chk_state(input string req, input bit exp_gain);
    chk(req, gain_bit, exp_gain);
    chk(req, icp_code, exp_gain ? cur_secondary : cur_primary);
  endtask

  task automatic write_gain(input bit v);
    @(negedge clk); gain_wr = 1'b1; gain_val = v;
    @(negedge clk); gain_wr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); pfd_tick = 1'b1;
    @(negedge clk); pfd_tick = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk_state("R1", 1'b0);

    // R2: every code pair, both gain states
    for (int g = 0; g < 2; g++) begin
      write_gain(g[0]);
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          cur_primary = a[2:0]; cur_secondary = b[2:0];
          #1;
          chk("R2", icp_code, g ? b : a);
        end
      end
    end
    cur_primary = 3'd1; cur_secondary = 3'd7;

    // R3 and R4: direct selection, no self-clear
    fl_enable = 1'b0; fl_mode = 1'b1; tc_code = 4'd0;
    write_gain(1'b1);
    chk_state("R3", 1'b1);
    for (int k = 0; k < 70; k++) tick();
    chk_state("R4", 1'b1);
    write_gain(1'b0);
    chk_state("R3", 1'b0);

    // R4: manual fastlock, ends only on a written 0
    fl_enable = 1'b1; fl_mode = 1'b0;
    write_gain(1'b1);
    for (int k = 0; k < 70; k++) tick();
    chk_state("R4", 1'b1);
    write_gain(1'b0);
    chk_state("R4", 1'b0);

    // R5: timed fastlock, every timeout code
    fl_mode = 1'b1;
    for (int tc = 0; tc < 16; tc++) begin
      int len;
      tc_code = tc[3:0];
      len = 3 + 4 * tc;
      write_gain(1'b1);
      for (int k = 1; k < len; k++) tick();
      chk_state("R5", 1'b1);
      tick();
      chk_state("R5", 1'b0);
    end

    // R6: rewrite restarts the count
    tc_code = 4'd1;  // timeout 7
    write_gain(1'b1);
    for (int k = 0; k < 5; k++) tick();
    write_gain(1'b1);
    for (int k = 0; k < 6; k++) tick();
    chk_state("R6", 1'b1);
    tick();
    chk_state("R6", 1'b0);

    // R6: a write on the expiring tick wins
    tc_code = 4'd0;  // timeout 3
    write_gain(1'b1);
    tick(); tick();
    @(negedge clk); gain_wr = 1'b1; gain_val = 1'b1; pfd_tick = 1'b1;
    @(negedge clk); gain_wr = 1'b0; pfd_tick = 1'b0;
    chk_state("R6", 1'b1);
    tick(); tick();
    chk_state("R6", 1'b1);
    tick();
    chk_state("R6", 1'b0);

    // R6: writing 0 cancels
    write_gain(1'b1);
    tick();
    write_gain(1'b0);
    chk_state("R6", 1'b0);

    // R7: power-down holds the timer and ignores ticks
    write_gain(1'b1);
    tick(); tick();
    @(negedge clk); pwr_down = 1'b1;
    for (int k = 0; k < 4; k++) tick();
    chk_state("R7", 1'b1);
    @(negedge clk); pwr_down = 1'b0;
    tick(); tick();
    chk_state("R7", 1'b1);
    tick();
    chk_state("R7", 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule